// File: doc/BRIEF.md
# Page Write Buffer Controller

This block collects the data bytes of one write transfer into a small page buffer and then commits them to a non-volatile memory array during a self-timed programming period. A bus engine in front of it decodes the serial protocol. For each write transfer it hands over the word address that the transfer starts at, then one strobe per received data byte, and finally the end-of-transfer (Stop) or repeated-Start event. The block returns a busy flag, which the bus engine uses to withhold acknowledges while programming is in progress.

Only the low offset bits of the address advance as bytes arrive, so a transfer never leaves its page. It wraps to the page start instead, and later bytes replace earlier ones. A per-byte valid mask limits the commit to the locations that were actually received. The programming time is a clock-count parameter, so simulation can use a short value while silicon uses the real write time. A write-protect input sampled at commit time lets the full busy period elapse without touching the array.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `arr_we` is 0.
- R2: A transfer loaded with address A writes its first byte to A and each further byte to the next offset. The page bits A[7:4] stay fixed for all writes of one commit, and no location outside that page is written.
- R3: The 4-bit offset wraps from 15 to 0 within the same page. Four bytes loaded at 0x3E land at 0x3E, 0x3F, 0x30 and 0x31.
- R4: When more than 16 bytes arrive before Stop, a later byte replaces the buffered byte at the same offset. Each page location is written at most once per commit, holding the last byte received for it.
- R5: Only offsets that received a byte are written. Every other location keeps its previous contents.
- R6: A Stop that follows at least one data byte starts the commit. `busy` is 1 in the cycle after the clock edge that captures the Stop.
- R7: A Stop before any data byte, or a repeated Start (`restart_seen`), ends the transfer with no commit: `busy` stays 0 and nothing is written. A later Stop does not revive the discarded bytes.
- R8: `busy` stays high for exactly CYCLE_CLKS clock cycles per commit.
- R9: If `wp_in` is 1 in the cycle Stop is captured, the full busy period still runs but `arr_we` never asserts.
- R10: While `busy` is 1, `addr_load`, `byte_vld`, `stop_seen` and `restart_seen` are ignored. They neither write the array nor extend the busy period, and they leave no transfer open afterwards.
- R11: The writes of one commit occur on distinct clocks, in strictly ascending offset order, one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Start of a write transfer; `addr_in` is valid |
| addr_in | input | ADDR_W | Word address the transfer begins at |
| byte_vld | input | 1 | One received data byte on `byte_data` |
| byte_data | input | DATA_W | Received data byte |
| stop_seen | input | 1 | Stop condition observed by the bus engine |
| restart_seen | input | 1 | Repeated Start observed; abandons the transfer |
| wp_in | input | 1 | Write-protect level, sampled when the commit starts |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming in progress; acknowledges are suppressed |

## Verification
On every cycle the checker holds the busy window to exactly CYCLE_CLKS clocks and requires each rise of busy to follow a Stop. It also forbids array writes while idle or under a write-protect latched at Stop, and keeps the page bits of the write address steady for the whole commit. The bench scenarios show what a property cannot see without the data path. Those are the offset wrap, the overwrite when more than 16 bytes arrive, the untouched neighbours of a partial page, ascending write order, and the discarding of data after an empty Stop, a repeated Start, or traffic during busy.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      PG_IDLE = 2'd0,
      PG_FILL = 2'd1,
      PG_PROG = 2'd2
   } pg_state_e;
endpackage

// File: rtl/pgwr_buf.sv
// Page buffer: one register and one valid bit per byte slot.
module pgwr_buf #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 16,
   localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr_en,
   input  logic [OFS_W-1:0]      wr_ofs,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [OFS_W-1:0]      rd_ofs,
   output logic [PAGE_BYTES-1:0] mask,
   output logic [DATA_W-1:0]     rd_data
);
   logic [DATA_W-1:0] slot_q [PAGE_BYTES];

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
      logic [DATA_W-1:0] d_q;
      logic              v_q;
      wire               hit = wr_en && (wr_ofs == OFS_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
         end else if (clr) begin
            v_q <= 1'b0;
         end else if (hit) begin
            d_q <= wr_data;
            v_q <= 1'b1;
         end
      end

      assign slot_q[i] = d_q;
      assign mask[i]   = v_q;
   end

   assign rd_data = slot_q[rd_ofs];
endmodule

// File: rtl/pgwr_timer.sv
// Self-timed programming window of CYCLE_CLKS clocks.
module pgwr_timer #(
   parameter int CYCLE_CLKS = 64,
   localparam int CNT_W     = $clog2(CYCLE_CLKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             run,
   output logic             last,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CYCLE_CLKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (start && !run) begin
         run <= 1'b1;
         cnt <= '0;
      end else if (run) begin
         if (cnt == CNT_END) begin
            run <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign last = run && (cnt == CNT_END);
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 16,
   parameter int CYCLE_CLKS = 500_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_seen,
   input  logic              restart_seen,
   input  logic              wp_in,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              busy
);
   import pgwr_pkg::*;

   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFS_W;
   localparam int CNT_W  = $clog2(CYCLE_CLKS);

   if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (PAGE_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width");
   end
   if (CYCLE_CLKS < PAGE_BYTES) begin : g_bad_cycle
      $error("CYCLE_CLKS must cover one clock per page byte");
   end

   pg_state_e         state_q;
   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ptr_q;
   logic              wp_q;

   logic [PAGE_BYTES-1:0] mask;
   logic [DATA_W-1:0]     slot_data;
   logic                  t_run, t_last, t_start;
   logic [CNT_W-1:0]      t_cnt;
   logic [OFS_W-1:0]      scan_ofs;
   logic                  scan_live;

   wire accept_load = addr_load && (state_q != PG_PROG);
   wire in_fill     = (state_q == PG_FILL);
   wire fill_byte   = in_fill && byte_vld && !addr_load;
   wire have_data   = |mask;

   assign t_start = in_fill && !addr_load && stop_seen && have_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PG_IDLE;
         page_q  <= '0;
         ptr_q   <= '0;
         wp_q    <= 1'b0;
      end else begin
         unique case (state_q)
            PG_IDLE: begin
               if (addr_load) begin
                  page_q  <= addr_in[ADDR_W-1:OFS_W];
                  ptr_q   <= addr_in[OFS_W-1:0];
                  state_q <= PG_FILL;
               end
            end
            PG_FILL: begin
               if (addr_load) begin
                  page_q <= addr_in[ADDR_W-1:OFS_W];
                  ptr_q  <= addr_in[OFS_W-1:0];
               end else if (stop_seen) begin
                  wp_q    <= wp_in;
                  state_q <= have_data ? PG_PROG : PG_IDLE;
               end else if (restart_seen) begin
                  state_q <= PG_IDLE;
               end else if (byte_vld) begin
                  ptr_q <= ptr_q + 1'b1;
               end
            end
            PG_PROG: begin
               if (t_last) state_q <= PG_IDLE;
            end
            default: state_q <= PG_IDLE;
         endcase
      end
   end

   pgwr_buf #(
      .DATA_W     (DATA_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept_load),
      .wr_en   (fill_byte && !stop_seen && !restart_seen),
      .wr_ofs  (ptr_q),
      .wr_data (byte_data),
      .rd_ofs  (scan_ofs),
      .mask    (mask),
      .rd_data (slot_data)
   );

   pgwr_timer #(
      .CYCLE_CLKS (CYCLE_CLKS)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (t_start),
      .run   (t_run),
      .last  (t_last),
      .cnt   (t_cnt)
   );

   assign scan_ofs = t_cnt[OFS_W-1:0];

   if (CNT_W > OFS_W) begin : g_scan_wide
      assign scan_live = (t_cnt[CNT_W-1:OFS_W] == '0);
   end else begin : g_scan_exact
      assign scan_live = 1'b1;
   end

   assign busy      = t_run;
   assign arr_we    = t_run && scan_live && mask[scan_ofs] && !wp_q;
   assign arr_addr  = {page_q, scan_ofs};
   assign arr_wdata = slot_data;
endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 16,
   parameter int CYCLE_CLKS = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_seen,
   input logic              wp_in,
   input logic              busy,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr
);
   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int LEN_W = $clog2(CYCLE_CLKS + 1) + 1;

   logic [LEN_W-1:0] busy_len;
   logic             wp_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_len <= '0;
         wp_seen  <= 1'b0;
      end else begin
         busy_len <= busy ? busy_len + 1'b1 : '0;
         if (stop_seen && !busy) wp_seen <= wp_in;
      end
   end

   // R1
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !arr_we);

   // R2
   page_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(arr_addr[ADDR_W-1:OFS_W]));

   // R6
   start_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_seen));

   // R8
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_len < LEN_W'(CYCLE_CLKS));

   // R8
   busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_len == LEN_W'(CYCLE_CLKS));

   // R9
   protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wp_seen |-> !arr_we);
endmodule

bind pgwr_ctrl pgwr_chk #(
   .ADDR_W     (ADDR_W),
   .PAGE_BYTES (PAGE_BYTES),
   .CYCLE_CLKS (CYCLE_CLKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stop_seen (stop_seen),
   .wp_in     (wp_in),
   .busy      (busy),
   .arr_we    (arr_we),
   .arr_addr  (arr_addr)
);

// File: tb/sim_pgwr_ctrl.sv
module sim_pgwr_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CYC        = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0;
   logic [7:0] addr_in = '0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_data = '0;
   logic       stop_seen = 1'b0;
   logic       restart_seen = 1'b0;
   logic       wp_in = 1'b0;
   logic       arr_we;
   logic [7:0] arr_addr;
   logic [7:0] arr_wdata;
   logic       busy;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] mem [256];
   int wr_cnt = 0;
   int run_len = 0;
   int last_run = 0;
   int ord_err = 0;
   int prev_ofs = -1;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgwr_ctrl #(.CYCLE_CLKS(CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .byte_vld(byte_vld), .byte_data(byte_data), .stop_seen(stop_seen),
      .restart_seen(restart_seen), .wp_in(wp_in), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy)
   );

   function automatic logic [7:0] init_val(int a);
      return 8'(a) ^ 8'hA5;
   endfunction

   // array model and busy/order monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (arr_we) begin
            mem[arr_addr] = arr_wdata;
            wr_cnt++;
            if (prev_ofs >= 0 && int'(arr_addr[3:0]) <= prev_ofs) ord_err++;
            prev_ofs = int'(arr_addr[3:0]);
         end
         if (busy) run_len++;
         else begin
            if (run_len != 0) last_run = run_len;
            run_len = 0;
            prev_ofs = -1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic load(input logic [7:0] a);
      @(posedge clk); #1 addr_load = 1'b1; addr_in = a;
      @(posedge clk); #1 addr_load = 1'b0;
   endtask

   task automatic send(input logic [7:0] d);
      @(posedge clk); #1 byte_vld = 1'b1; byte_data = d;
      @(posedge clk); #1 byte_vld = 1'b0;
   endtask

   task automatic stop();
      @(posedge clk); #1 stop_seen = 1'b1;
      @(posedge clk); #1 stop_seen = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 4 * CYC && busy; i++) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);
   endtask

   task automatic t_basic();
      int w0 = wr_cnt;
      load(8'h35);
      send(8'hA1); send(8'hB2); send(8'hC3);
      stop();
      chk(busy == 1'b1, "R6 busy after stop", int'(busy), 1);
      wait_done();
      chk(mem[8'h35] == 8'hA1, "R2 first byte", mem[8'h35], 8'hA1);
      chk(mem[8'h36] == 8'hB2, "R2 second byte", mem[8'h36], 8'hB2);
      chk(mem[8'h37] == 8'hC3, "R2 third byte", mem[8'h37], 8'hC3);
      chk(mem[8'h34] == init_val(8'h34), "R5 lower neighbour", mem[8'h34], init_val(8'h34));
      chk(mem[8'h38] == init_val(8'h38), "R5 upper neighbour", mem[8'h38], init_val(8'h38));
      chk(wr_cnt - w0 == 3, "R5 write count", wr_cnt - w0, 3);
      chk(last_run == CYC, "R8 busy length", last_run, CYC);
      chk(ord_err == 0, "R11 write order", ord_err, 0);
   endtask

   task automatic t_wrap();
      int w0 = wr_cnt;
      load(8'h3E);
      send(8'h11); send(8'h22); send(8'h33); send(8'h44);
      stop();
      wait_done();
      chk(mem[8'h3E] == 8'h11, "R3 offset E", mem[8'h3E], 8'h11);
      chk(mem[8'h3F] == 8'h22, "R3 offset F", mem[8'h3F], 8'h22);
      chk(mem[8'h30] == 8'h33, "R3 wrap to 0", mem[8'h30], 8'h33);
      chk(mem[8'h31] == 8'h44, "R3 wrap to 1", mem[8'h31], 8'h44);
      chk(mem[8'h40] == init_val(8'h40), "R2 next page untouched", mem[8'h40], init_val(8'h40));
      chk(wr_cnt - w0 == 4, "R3 write count", wr_cnt - w0, 4);
      chk(ord_err == 0, "R11 wrapped order", ord_err, 0);
   endtask

   task automatic t_overwrite();
      int w0 = wr_cnt;
      int bad = 0;
      load(8'h50);
      for (int i = 0; i < 18; i++) send(8'(8'h10 + i));
      stop();
      wait_done();
      for (int k = 0; k < 16; k++) begin
         logic [7:0] e = (k < 2) ? 8'(8'h20 + k) : 8'(8'h10 + k);
         if (mem[8'h50 + k] != e) bad++;
      end
      chk(bad == 0, "R4 page contents", bad, 0);
      chk(mem[8'h50] == 8'h20, "R4 offset 0 replaced", mem[8'h50], 8'h20);
      chk(wr_cnt - w0 == 16, "R4 one write per slot", wr_cnt - w0, 16);
      chk(last_run == CYC, "R8 full page length", last_run, CYC);
   endtask

   task automatic t_no_commit();
      int w0 = wr_cnt;
      load(8'h70);
      stop();
      chk(busy == 1'b0, "R7 empty stop", int'(busy), 0);
      load(8'h70);
      send(8'h99); send(8'h98);
      @(posedge clk); #1 restart_seen = 1'b1;
      @(posedge clk); #1 restart_seen = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R7 restart no busy", int'(busy), 0);
      stop();
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R7 late stop no busy", int'(busy), 0);
      chk(wr_cnt == w0, "R7 no writes", wr_cnt - w0, 0);
      chk(mem[8'h70] == init_val(8'h70), "R7 array intact", mem[8'h70], init_val(8'h70));
   endtask

   task automatic t_protect();
      int w0 = wr_cnt;
      last_run = 0;
      wp_in = 1'b1;
      load(8'h80);
      send(8'h5A); send(8'h5B);
      stop();
      wp_in = 1'b0;
      chk(busy == 1'b1, "R9 busy under protect", int'(busy), 1);
      wait_done();
      chk(last_run == CYC, "R9 full length", last_run, CYC);
      chk(wr_cnt == w0, "R9 no writes", wr_cnt - w0, 0);
      chk(mem[8'h80] == init_val(8'h80), "R9 array intact", mem[8'h80], init_val(8'h80));
   endtask

   task automatic t_busy_ignore();
      int w0 = wr_cnt;
      load(8'h90);
      send(8'h77);
      stop();
      load(8'hA0);
      send(8'h55);
      stop();
      wait_done();
      chk(wr_cnt - w0 == 1, "R10 single write", wr_cnt - w0, 1);
      chk(mem[8'h90] == 8'h77, "R10 real data", mem[8'h90], 8'h77);
      chk(mem[8'hA0] == init_val(8'hA0), "R10 busy byte dropped", mem[8'hA0], init_val(8'hA0));
      chk(last_run == CYC, "R10 not extended", last_run, CYC);
      stop();
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R10 no open transfer", int'(busy), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = init_val(a);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_wrap();
      t_overwrite();
      t_no_commit();
      t_protect();
      t_busy_ignore();
      finish_up();
   end
endmodule